// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block sits behind the receive byte stream of an Ethernet MAC and decides, frame by frame, whether an incoming frame should be kept. It gathers the first six bytes of each frame, which hold the 48-bit destination address. It then classifies that address as broadcast, multicast (group) or unicast. The class is weighed against a set of accept enables and a stored station address. The verdict appears one cycle after the sixth byte.

At the end of the frame the block applies the length rules to the raw byte count. A runt below eight bytes is dropped. A short frame is reported at its padded size of 64 bytes: 60 bytes of zero-padded data plus a 4-byte frame check sequence. An oversize frame is clipped to 1518 bytes. Each match class that hits, and each accepted frame, sets a flag in two 16-bit words. The status word describes the current frame and is cleared when the next frame starts. The event word is sticky until the host clears it. An optional interrupt pulse marks accepted frames.

Top module: `rx_dest_filter`

## Requirements
- R1: `addr_done` pulses for exactly one cycle, in the cycle after the sixth byte of a frame is taken (`byte_vld` high; the frame's first byte comes with `sof`). `addr_hit` gives the address verdict from that cycle on and is cleared by the next `sof`. A frame that ends with fewer than six bytes is never accepted.
- R2: While `line_rx_on` is low when the sixth byte is taken, the address is rejected whatever the other enables say.
- R3: With `acc_prom` high, every destination is accepted and no class flag is set.
- R4: The all-ones destination is accepted only when `acc_bcast` is high, and then sets bit 11 (0x0800) in both `evt_word` and `sts_word`. Broadcast is tested before multicast: with `acc_bcast` low the all-ones address is rejected even when `acc_mcast` is high.
- R5: A destination whose first byte has bit 0 set (group address, not all-ones) is accepted only when `acc_mcast` is high, and then sets bit 9 (0x0200) in both words.
- R6: A unicast destination with `acc_ucast` high is accepted only if it equals `station_addr` (first received byte in bits 47:40), and then sets bit 10 (0x0400). With `acc_ucast` low, a unicast destination is accepted with no flag.
- R7: `frm_done` pulses in the cycle after `eof`. At that point `frm_len` and `frm_pad` are updated from `frame_len`, and hold until the next `eof`:
  - below 8: length 0, frame dropped;
  - 8 to 63: length 64, `frm_pad` high;
  - above 1518: length 1518;
  - otherwise: `frame_len` unchanged.
- R8: `frm_ok` pulses with `frm_done` when the address was accepted and the frame is not a runt. It sets bit 8 (0x0100) in both words. `rx_irq` pulses with it when `rxok_ie` is high at `eof`.
- R9: `sts_word` is cleared by `sof`. `evt_word` keeps its bits until `evt_clr`. A flag set in the same cycle as `evt_clr` survives the clear.
- R10: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Marks the first byte of a frame |
| byte_vld | input | 1 | Byte strobe |
| byte_dat | input | 8 | Received byte |
| eof | input | 1 | End of frame, with `frame_len` |
| frame_len | input | 16 | Raw frame length in bytes |
| station_addr | input | 48 | Own address, first byte in 47:40 |
| line_rx_on | input | 1 | Receiver enable |
| acc_prom | input | 1 | Accept all destinations |
| acc_bcast | input | 1 | Accept broadcast |
| acc_mcast | input | 1 | Accept multicast |
| acc_ucast | input | 1 | Require station match for unicast |
| rxok_ie | input | 1 | Interrupt enable for accepted frames |
| evt_clr | input | 1 | Clears the event word |
| addr_done | output | 1 | Address verdict strobe |
| addr_hit | output | 1 | Address accepted |
| frm_done | output | 1 | Frame verdict strobe |
| frm_ok | output | 1 | Frame accepted |
| frm_len | output | 16 | Effective frame length |
| frm_pad | output | 1 | Frame was padded |
| rx_irq | output | 1 | Accepted-frame interrupt pulse |
| evt_word | output | 16 | Sticky event flags |
| sts_word | output | 16 | Per-frame status flags |

## Verification
The event word has two writers that can act in the same cycle: the host's clear and a flag set by the filter. There are two such sets, the receive-OK bit at end of frame and a class flag from the address verdict. The bench raises `evt_clr` in the very cycle that carries `eof` of an accepted frame, and in the cycle of a sixth address byte. After each of these edges it expects only the freshly set bit to remain. A behavioural model, built on a byte queue, recomputes both words every clock and judges the outcome.

// File: rtl/rx_dest_filter_pkg.sv
package rx_dest_filter_pkg;

    localparam int ADDR_W     = 48;
    localparam int FLAG_W     = 16;
    localparam int FLAG_RXOK  = 8;
    localparam int FLAG_MCAST = 9;
    localparam int FLAG_UCAST = 10;
    localparam int FLAG_BCAST = 11;

    typedef enum logic [1:0] {
        DST_UCAST,
        DST_MCAST,
        DST_BCAST
    } dst_class_e;

    typedef struct packed {
        logic              hit;
        logic [FLAG_W-1:0] flags;
    } addr_verdict_t;

    typedef struct packed {
        logic        keep;
        logic        pad;
        logic [15:0] len;
    } len_verdict_t;

    function automatic dst_class_e classify(input logic [ADDR_W-1:0] dst);
        if (&dst)
            return DST_BCAST;
        else if (dst[ADDR_W-8])
            return DST_MCAST;
        else
            return DST_UCAST;
    endfunction

    function automatic logic [FLAG_W-1:0] flag_bit(input int pos);
        logic [FLAG_W-1:0] f;
        f = '0;
        f[pos] = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/rx_dest_collect.sv
module rx_dest_collect #(
    parameter int ADDR_BYTES = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sof,
    input  logic                  byte_vld,
    input  logic [7:0]            byte_dat,
    output logic [ADDR_BYTES*8-1:0] dst_now,
    output logic                  last_byte
);
    localparam int DW    = ADDR_BYTES * 8;
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);

    logic [DW-1:0]    dst_q;
    logic [CNT_W-1:0] cnt_q;

    assign dst_now   = {dst_q[DW-9:0], byte_dat};
    assign last_byte = byte_vld && !sof && (cnt_q == CNT_W'(ADDR_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_q <= '0;
            cnt_q <= '0;
        end else if (byte_vld) begin
            if (sof) begin
                dst_q <= {{(DW-8){1'b0}}, byte_dat};
                cnt_q <= CNT_W'(1);
            end else if (cnt_q < CNT_W'(ADDR_BYTES)) begin
                dst_q <= dst_now;
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/rx_dest_match.sv
module rx_dest_match
    import rx_dest_filter_pkg::*;
(
    input  logic [ADDR_W-1:0] dst,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic              line_rx_on,
    input  logic              acc_prom,
    input  logic              acc_bcast,
    input  logic              acc_mcast,
    input  logic              acc_ucast,
    output addr_verdict_t     verdict
);
    dst_class_e cls;

    always_comb begin
        cls           = classify(dst);
        verdict.hit   = 1'b0;
        verdict.flags = '0;
        if (!line_rx_on) begin
            verdict.hit = 1'b0;
        end else if (acc_prom) begin
            verdict.hit = 1'b1;
        end else begin
            unique case (cls)
                DST_BCAST: begin
                    verdict.hit = acc_bcast;
                    if (acc_bcast) verdict.flags = flag_bit(FLAG_BCAST);
                end
                DST_MCAST: begin
                    verdict.hit = acc_mcast;
                    if (acc_mcast) verdict.flags = flag_bit(FLAG_MCAST);
                end
                default: begin
                    if (acc_ucast) begin
                        verdict.hit = (dst == station_addr);
                        if (dst == station_addr) verdict.flags = flag_bit(FLAG_UCAST);
                    end else begin
                        verdict.hit = 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/rx_len_rules.sv
module rx_len_rules
    import rx_dest_filter_pkg::*;
#(
    parameter int MIN_LEN = 8,
    parameter int PAD_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input  logic [15:0]  raw_len,
    output len_verdict_t verdict
);
    always_comb begin
        verdict.keep = 1'b1;
        verdict.pad  = 1'b0;
        verdict.len  = raw_len;
        if (raw_len < 16'(MIN_LEN)) begin
            verdict.keep = 1'b0;
            verdict.len  = '0;
        end else if (raw_len < 16'(PAD_LEN)) begin
            verdict.pad = 1'b1;
            verdict.len = 16'(PAD_LEN);
        end else if (raw_len > 16'(MAX_LEN)) begin
            verdict.len = 16'(MAX_LEN);
        end
    end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rx_dest_filter_pkg::*;
#(
    parameter int MIN_LEN = 8,
    parameter int PAD_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sof,
    input  logic        byte_vld,
    input  logic [7:0]  byte_dat,
    input  logic        eof,
    input  logic [15:0] frame_len,
    input  logic [47:0] station_addr,
    input  logic        line_rx_on,
    input  logic        acc_prom,
    input  logic        acc_bcast,
    input  logic        acc_mcast,
    input  logic        acc_ucast,
    input  logic        rxok_ie,
    input  logic        evt_clr,
    output logic        addr_done,
    output logic        addr_hit,
    output logic        frm_done,
    output logic        frm_ok,
    output logic [15:0] frm_len,
    output logic        frm_pad,
    output logic        rx_irq,
    output logic [15:0] evt_word,
    output logic [15:0] sts_word
);
    localparam int ADDR_BYTES = ADDR_W / 8;

    logic [ADDR_W-1:0] dst_now;
    logic              last_byte;
    addr_verdict_t     av;
    len_verdict_t      lv;
    logic              decided_q;
    logic              ok_now;
    logic [FLAG_W-1:0] set_mask;

    rx_dest_collect #(.ADDR_BYTES(ADDR_BYTES)) u_collect (
        .clk       (clk),
        .rst       (rst),
        .sof       (sof),
        .byte_vld  (byte_vld),
        .byte_dat  (byte_dat),
        .dst_now   (dst_now),
        .last_byte (last_byte)
    );

    rx_dest_match u_match (
        .dst          (dst_now),
        .station_addr (station_addr),
        .line_rx_on   (line_rx_on),
        .acc_prom     (acc_prom),
        .acc_bcast    (acc_bcast),
        .acc_mcast    (acc_mcast),
        .acc_ucast    (acc_ucast),
        .verdict      (av)
    );

    rx_len_rules #(.MIN_LEN(MIN_LEN), .PAD_LEN(PAD_LEN), .MAX_LEN(MAX_LEN)) u_len (
        .raw_len (frame_len),
        .verdict (lv)
    );

    assign ok_now   = eof && decided_q && addr_hit && lv.keep;
    assign set_mask = (last_byte && av.hit ? av.flags : '0)
                    | (ok_now ? flag_bit(FLAG_RXOK) : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_done <= 1'b0;
            addr_hit  <= 1'b0;
            decided_q <= 1'b0;
            frm_done  <= 1'b0;
            frm_ok    <= 1'b0;
            frm_len   <= '0;
            frm_pad   <= 1'b0;
            rx_irq    <= 1'b0;
            evt_word  <= '0;
            sts_word  <= '0;
        end else begin
            addr_done <= last_byte;
            if (sof && byte_vld) begin
                addr_hit  <= 1'b0;
                decided_q <= 1'b0;
            end else if (last_byte) begin
                addr_hit  <= av.hit;
                decided_q <= 1'b1;
            end
            frm_done <= eof;
            frm_ok   <= ok_now;
            rx_irq   <= ok_now && rxok_ie;
            if (eof) begin
                frm_len <= lv.len;
                frm_pad <= lv.pad;
            end
            evt_word <= (evt_clr ? '0 : evt_word) | set_mask;
            sts_word <= ((sof && byte_vld) ? '0 : sts_word) | set_mask;
        end
    end
endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk #(
    parameter int PAD_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input logic        clk,
    input logic        rst,
    input logic        sof,
    input logic        byte_vld,
    input logic        eof,
    input logic        line_rx_on,
    input logic        addr_done,
    input logic        addr_hit,
    input logic        frm_done,
    input logic        frm_ok,
    input logic [15:0] frm_len,
    input logic        rx_irq,
    input logic [15:0] sts_word
);
    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        addr_done |=> !addr_done);

    assert_line_gate_R2: assert property (@(posedge clk) disable iff (rst)
        (addr_done && addr_hit) |-> $past(line_rx_on));

    assert_one_class_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sts_word[11], sts_word[10], sts_word[9]}));

    assert_flag_bits_R5: assert property (@(posedge clk) disable iff (rst)
        (sts_word & 16'hF0FF) == 16'h0000);

    assert_len_window_R7: assert property (@(posedge clk) disable iff (rst)
        frm_ok |-> (frm_len >= 16'(PAD_LEN) && frm_len <= 16'(MAX_LEN)));

    assert_ok_flag_R8: assert property (@(posedge clk) disable iff (rst)
        frm_ok |-> (frm_done && sts_word[8]));

    assert_irq_ok_R8: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> frm_ok);

    assert_sts_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (sof && byte_vld && !eof) |=> (sts_word == 16'h0000));
endmodule

bind rx_dest_filter rx_dest_filter_chk #(.PAD_LEN(PAD_LEN), .MAX_LEN(MAX_LEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sof        (sof),
    .byte_vld   (byte_vld),
    .eof        (eof),
    .line_rx_on (line_rx_on),
    .addr_done  (addr_done),
    .addr_hit   (addr_hit),
    .frm_done   (frm_done),
    .frm_ok     (frm_ok),
    .frm_len    (frm_len),
    .rx_irq     (rx_irq),
    .sts_word   (sts_word)
);

// File: tb/test_rx_dest_filter.sv
module test_rx_dest_filter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sof = 0, byte_vld = 0, eof = 0, evt_clr = 0;
    logic [7:0]  byte_dat = 0;
    logic [15:0] frame_len = 0;
    logic [47:0] station_addr = 48'h02_62_9C_61_CF_16;
    logic        line_rx_on = 0, acc_prom = 0, acc_bcast = 0, acc_mcast = 0, acc_ucast = 0, rxok_ie = 0;
    logic        addr_done, addr_hit, frm_done, frm_ok, frm_pad, rx_irq;
    logic [15:0] frm_len, evt_word, sts_word;

    always #2 clk = ~clk;

    rx_dest_filter i_rx_dest_filter (.*);

    int checks = 0, fails = 0;
    string cur_req = "R10";
    bit started = 0;
    bit done_run = 0;

    logic [7:0] q[$];
    bit   m_done, m_hit, m_decided, m_fdone, m_ok, m_pad, m_irq;
    int   m_len;
    logic [15:0] m_evt, m_sts;

    always @(posedge clk) begin
        logic [15:0] sets;
        bit hit;
        logic [47:0] d;
        started <= 1'b1;
        if (rst) begin
            q.delete();
            m_done = 0; m_hit = 0; m_decided = 0; m_fdone = 0; m_ok = 0;
            m_pad = 0; m_irq = 0; m_len = 0; m_evt = 0; m_sts = 0;
        end else begin
            sets = 0;
            m_done = 0;
            if (byte_vld) begin
                if (sof) begin q.delete(); m_hit = 0; m_decided = 0; end
                q.push_back(byte_dat);
                if (q.size() == 6) begin
                    d = {q[0], q[1], q[2], q[3], q[4], q[5]};
                    hit = 0;
                    if (!line_rx_on) hit = 0;
                    else if (acc_prom) hit = 1;
                    else if (d == 48'hFFFF_FFFF_FFFF) begin
                        hit = acc_bcast; if (hit) sets[11] = 1;
                    end else if (q[0][0]) begin
                        hit = acc_mcast; if (hit) sets[9] = 1;
                    end else if (acc_ucast) begin
                        hit = (d == station_addr); if (hit) sets[10] = 1;
                    end else hit = 1;
                    m_done = 1; m_hit = hit; m_decided = 1;
                end
            end
            m_fdone = eof; m_ok = 0; m_irq = 0;
            if (eof) begin
                int L;
                L = frame_len;
                m_pad = 0;
                if (L < 8) m_len = 0;
                else if (L < 64) begin m_len = 64; m_pad = 1; end
                else if (L > 1518) m_len = 1518;
                else m_len = L;
                m_ok = m_decided && m_hit && (L >= 8);
                m_irq = m_ok && rxok_ie;
                if (m_ok) sets[8] = 1;
            end
            m_evt = (evt_clr ? 16'h0 : m_evt) | sets;
            m_sts = ((sof && byte_vld) ? 16'h0 : m_sts) | sets;
        end
    end

    task automatic cmp(string name, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual %0h expected %0h at %0t", cur_req, name, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done_run) begin
            cmp("addr_done", int'(addr_done), int'(m_done));
            cmp("addr_hit",  int'(addr_hit),  int'(m_hit));
            cmp("frm_done",  int'(frm_done),  int'(m_fdone));
            cmp("frm_ok",    int'(frm_ok),    int'(m_ok));
            cmp("frm_len",   int'(frm_len),   m_len);
            cmp("frm_pad",   int'(frm_pad),   int'(m_pad));
            cmp("rx_irq",    int'(rx_irq),    int'(m_irq));
            cmp("evt_word",  int'(evt_word),  int'(m_evt));
            cmp("sts_word",  int'(sts_word),  int'(m_sts));
        end
    end

    task automatic frame(input logic [47:0] d, input int nb, input int len,
                         input bit clr_eof, input bit clr_last);
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            sof = (i == 0); byte_vld = 1;
            byte_dat = (i < 6) ? d[47-8*i -: 8] : 8'(i);
            evt_clr = clr_last && (i == 5);
        end
        @(negedge clk);
        sof = 0; byte_vld = 0; evt_clr = clr_eof; eof = 1; frame_len = 16'(len);
        @(negedge clk);
        eof = 0; evt_clr = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cfg(bit ln, bit pr, bit bc, bit mc, bit uc, bit ie);
        @(negedge clk);
        line_rx_on = ln; acc_prom = pr; acc_bcast = bc; acc_mcast = mc; acc_ucast = uc; rxok_ie = ie;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        cur_req = "R10"; repeat (2) @(negedge clk);
        cur_req = "R2";  cfg(0,1,1,1,0,1); frame(48'hFFFF_FFFF_FFFF, 8, 100, 0, 0);
        cur_req = "R3";  cfg(1,1,0,0,1,0); frame(48'h0A_00_00_00_00_01, 8, 100, 0, 0);
                                           frame(48'h01_00_5E_00_00_01, 8, 100, 0, 0);
        cur_req = "R4";  cfg(1,0,1,0,0,1); frame(48'hFFFF_FFFF_FFFF, 7, 200, 0, 0);
                         cfg(1,0,0,1,0,1); frame(48'hFFFF_FFFF_FFFF, 7, 200, 0, 0);
        cur_req = "R5";  cfg(1,0,0,1,0,0); frame(48'h01_00_5E_7F_00_09, 7, 80, 0, 0);
                         cfg(1,0,1,0,1,0); frame(48'h33_33_00_00_00_01, 7, 80, 0, 0);
        cur_req = "R6";  cfg(1,0,0,0,1,1); frame(station_addr, 6, 300, 0, 0);
                         frame(48'h02_62_9C_61_CF_17, 6, 300, 0, 0);
                         cfg(1,0,0,0,0,1); frame(48'h00_11_22_33_44_55, 6, 300, 0, 0);
        cur_req = "R7";  cfg(1,1,0,0,0,1);
                         frame(48'h00_11_22_33_44_55, 6, 5, 0, 0);
                         frame(48'h00_11_22_33_44_55, 6, 8, 0, 0);
                         frame(48'h00_11_22_33_44_55, 6, 40, 0, 0);
                         frame(48'h00_11_22_33_44_55, 6, 63, 0, 0);
                         frame(48'h00_11_22_33_44_55, 6, 64, 0, 0);
                         frame(48'h00_11_22_33_44_55, 6, 1518, 0, 0);
                         frame(48'h00_11_22_33_44_55, 6, 2000, 0, 0);
        cur_req = "R1";  frame(48'h00_11_22_33_44_55, 3, 100, 0, 0);
        cur_req = "R8";  cfg(1,0,1,0,0,0); frame(48'hFFFF_FFFF_FFFF, 6, 90, 0, 0);
                         cfg(1,0,1,0,0,1); frame(48'hFFFF_FFFF_FFFF, 6, 90, 0, 0);
        cur_req = "R9";  @(negedge clk); evt_clr = 1; @(negedge clk); evt_clr = 0;
                         cfg(1,0,0,1,0,1); frame(48'h01_00_5E_00_00_02, 6, 90, 1, 0);
                         frame(48'h01_00_5E_00_00_03, 6, 90, 0, 1);
                         cfg(1,0,0,0,1,0); frame(48'h00_00_00_00_00_07, 6, 90, 0, 0);
        repeat (4) @(negedge clk);
        done_run = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 50000);
        if (!done_run) begin
            done_run = 1;
            checks++; fails++;
            $display("FAIL watchdog expired during %s", cur_req);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule